// File: doc/BRIEF.md
# Internal Address Space Decoder for Port I/O and Configuration Access

This block sits behind a processor's address generation and turns requests aimed at an internal (non-memory) address space into physical requests. A request is one address word plus an access size in bytes. The field above bit 3 of the address selects the space: a register space, whose offset becomes a register-mapped physical address, or the I/O port space, whose offset is a 16-bit port number. Any other space code is reported on an error output.

Inside the I/O space the block owns one 32-bit configuration-address register. A four-byte access to port 0xCF8 reaches that register, where a write loads it on the clock edge and a read returns its contents. The four ports 0xCFC to 0xCFF form a data window. While the register's top bit is set, a window access is redirected into configuration space, built from register bits 30:2 and the two low port bits. While that bit is clear, the access stays a plain I/O access. Every port access other than the register access is marked uncacheable. The response is combinational in the request cycle.

Top module: `ispace_decoder`

## Requirements
- R1: The space code is `req_addr[63:35]` (the address shifted right by 3, bits at and above `PFX_LSB`=32). Code 1 is the register space, code 2 is the I/O space, and every other code with `req_valid` high sets `rsp_err`.
- R2: A register-space request drives `rsp_regmap`=1 and `rsp_uncache`=0, with `rsp_paddr` = offset×8, where the offset is `req_addr[34:3]`.
- R3: In the I/O space the port is `req_addr[34:3]`. When any port bit above bit 15 is set, `rsp_err`=1.
- R4: An I/O access of size 4 to port 0xCF8 drives `rsp_regmap`=1, `rsp_uncache`=0, `rsp_paddr`=`CFG_REG_PADDR` (0x400), and `rsp_rdata` = the configuration-address register. For every other request `rsp_rdata` is 0.
- R5: A request that matches R4 with `req_write`=1 loads `req_wdata` into the configuration-address register on the rising edge. Reads, other sizes, other ports and error requests leave it unchanged.
- R6: A window access (port 0xCFC..0xCFF) while register bit 31 is 1 drives `rsp_paddr` = `CFG_PFX` (0xC000_0000_0000_0000) | {register[30:2], port[1:0]}, with `rsp_uncache`=1.
- R7: A window access while register bit 31 is 0 drives `rsp_paddr` = `IO_PFX` (0x8000_0000_0000_0000) | port, with `rsp_uncache`=1.
- R8: Any other in-range port (0xCF8 included when the size is not 4) drives `rsp_paddr` = `IO_PFX` | port, `rsp_uncache`=1, `rsp_regmap`=0.
- R9: On an error, `rsp_paddr`, `rsp_uncache`, `rsp_regmap` and `rsp_rdata` are 0. With `req_valid` low all outputs are 0.
- R10: After reset the configuration-address register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Internal-space address word |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data for the configuration-address register |
| rsp_paddr | output | 64 | Physical address produced |
| rsp_uncache | output | 1 | Access must bypass caches |
| rsp_regmap | output | 1 | Access targets an internal mapped register |
| rsp_err | output | 1 | Unknown space code or port out of range |
| rsp_rdata | output | 32 | Configuration-address register value on a register read |

## Verification
On every cycle the assertions check that the flags are mutually exclusive, that an idle cycle or an error gives all-zero outputs, that an unknown space code always raises the error, that a window access keeps the two low port bits in the result, and that a register read returns the last value loaded. Only the bench scenarios show the full address values: the register-space scaling, the switch of the window between configuration and I/O space as bit 31 is toggled by writes, and the fact that reads, wrong sizes and faulting requests never disturb the register.

// File: rtl/ispace_pkg.sv
package ispace_pkg;
   typedef enum logic [1:0] {
      SPACE_IDLE = 2'd0,
      SPACE_REG  = 2'd1,
      SPACE_IO   = 2'd2,
      SPACE_BAD  = 2'd3
   } space_e;

   localparam logic [15:0] PORT_CFG_ADDR = 16'h0CF8;
   localparam logic [15:0] PORT_WINDOW   = 16'h0CFC;
   localparam int unsigned PORT_W        = 16;
   localparam int unsigned CFG_W         = 32;
endpackage

// File: rtl/ispace_classify.sv
module ispace_classify
   import ispace_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PFX_LSB  = 32,
   parameter int unsigned REG_CODE = 1,
   parameter int unsigned IO_CODE  = 2
) (
   input  logic                valid,
   input  logic [ADDR_W-1:0]   addr,
   output space_e              space,
   output logic [PFX_LSB-1:0]  offset
);
   localparam int unsigned SH_W  = ADDR_W - 3;
   localparam int unsigned PFX_W = SH_W - PFX_LSB;

   initial begin
      assert (PFX_LSB >= PORT_W) else $error("PFX_LSB must cover a 16-bit port");
      assert (SH_W > PFX_LSB) else $error("ADDR_W leaves no prefix field");
   end

   logic [SH_W-1:0]  shifted;
   logic [PFX_W-1:0] code;

   assign shifted = addr[ADDR_W-1:3];
   assign code    = shifted[SH_W-1:PFX_LSB];
   assign offset  = shifted[PFX_LSB-1:0];

   always_comb begin
      if (!valid)                       space = SPACE_IDLE;
      else if (code == PFX_W'(REG_CODE)) space = SPACE_REG;
      else if (code == PFX_W'(IO_CODE))  space = SPACE_IO;
      else                               space = SPACE_BAD;
   end
endmodule

// File: rtl/ispace_io_steer.sv
module ispace_io_steer
   import ispace_pkg::*;
#(
   parameter int unsigned     PA_W          = 64,
   parameter int unsigned     OFS_W         = 32,
   parameter logic [PA_W-1:0] IO_PFX        = 64'h8000_0000_0000_0000,
   parameter logic [PA_W-1:0] CFG_PFX       = 64'hC000_0000_0000_0000,
   parameter logic [PA_W-1:0] CFG_REG_PADDR = 64'h0000_0000_0000_0400
) (
   input  logic [OFS_W-1:0] offset,
   input  logic [3:0]       size,
   input  logic [CFG_W-1:0] cfg,
   output logic             port_bad,
   output logic             cfg_hit,
   output logic             regmap,
   output logic             uncache,
   output logic [PA_W-1:0]  paddr
);
   localparam logic [PORT_W-1:0] WIN_MASK = ~PORT_W'(3);

   initial begin
      assert (PA_W >= CFG_W) else $error("PA_W narrower than config address");
      assert (PA_W > PORT_W) else $error("PA_W narrower than a port");
   end

   logic [PORT_W-1:0] port;
   logic              in_window;
   assign port = offset[PORT_W-1:0];

   generate
      if (OFS_W > PORT_W) begin : g_range_chk
         assign port_bad = |offset[OFS_W-1:PORT_W];
      end else begin : g_no_range_chk
         assign port_bad = 1'b0;
      end
   endgenerate

   assign cfg_hit   = (port == PORT_CFG_ADDR) && (size == 4'd4);
   assign in_window = (port & WIN_MASK) == PORT_WINDOW;

   always_comb begin
      regmap  = 1'b0;
      uncache = 1'b1;
      paddr   = IO_PFX | PA_W'(port);
      if (cfg_hit) begin
         regmap  = 1'b1;
         uncache = 1'b0;
         paddr   = CFG_REG_PADDR;
      end else if (in_window && cfg[CFG_W-1]) begin
         paddr = CFG_PFX | PA_W'({cfg[CFG_W-2:2], port[1:0]});
      end
   end
endmodule

// File: rtl/ispace_cfg_reg.sv
module ispace_cfg_reg
   import ispace_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= RESET_VAL;
      else if (load) value <= wdata;
   end
endmodule

// File: rtl/ispace_decoder.sv
module ispace_decoder
   import ispace_pkg::*;
#(
   parameter int unsigned     ADDR_W        = 64,
   parameter int unsigned     PA_W          = 64,
   parameter int unsigned     PFX_LSB       = 32,
   parameter int unsigned     REG_CODE      = 1,
   parameter int unsigned     IO_CODE       = 2,
   parameter logic [PA_W-1:0] IO_PFX        = 64'h8000_0000_0000_0000,
   parameter logic [PA_W-1:0] CFG_PFX       = 64'hC000_0000_0000_0000,
   parameter logic [PA_W-1:0] CFG_REG_PADDR = 64'h0000_0000_0000_0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_size,
   input  logic              req_write,
   input  logic [31:0]       req_wdata,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_uncache,
   output logic              rsp_regmap,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata
);
   initial begin
      assert (PA_W >= PFX_LSB + 3) else $error("PA_W too small for register offsets");
      assert (REG_CODE != IO_CODE) else $error("space codes must differ");
   end

   space_e             space;
   logic [PFX_LSB-1:0] offset;
   logic               port_bad, cfg_hit, io_regmap, io_uncache, cfg_load;
   logic [PA_W-1:0]    io_paddr;
   logic [CFG_W-1:0]   cfg_q;

   ispace_classify #(
      .ADDR_W(ADDR_W), .PFX_LSB(PFX_LSB), .REG_CODE(REG_CODE), .IO_CODE(IO_CODE)
   ) u_classify (
      .valid(req_valid), .addr(req_addr), .space(space), .offset(offset)
   );

   ispace_io_steer #(
      .PA_W(PA_W), .OFS_W(PFX_LSB), .IO_PFX(IO_PFX), .CFG_PFX(CFG_PFX),
      .CFG_REG_PADDR(CFG_REG_PADDR)
   ) u_steer (
      .offset(offset), .size(req_size), .cfg(cfg_q), .port_bad(port_bad),
      .cfg_hit(cfg_hit), .regmap(io_regmap), .uncache(io_uncache), .paddr(io_paddr)
   );

   assign cfg_load = (space == SPACE_IO) && !port_bad && cfg_hit && req_write;

   ispace_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .wdata(req_wdata), .value(cfg_q)
   );

   always_comb begin
      rsp_paddr   = '0;
      rsp_uncache = 1'b0;
      rsp_regmap  = 1'b0;
      rsp_err     = 1'b0;
      rsp_rdata   = '0;
      unique case (space)
         SPACE_REG: begin
            rsp_regmap = 1'b1;
            rsp_paddr  = PA_W'({offset, 3'b000});
         end
         SPACE_IO: begin
            if (port_bad) begin
               rsp_err = 1'b1;
            end else begin
               rsp_paddr   = io_paddr;
               rsp_uncache = io_uncache;
               rsp_regmap  = io_regmap;
               if (cfg_hit) rsp_rdata = cfg_q;
            end
         end
         SPACE_BAD:  rsp_err = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/ispace_checker.sv
module ispace_checker #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned PA_W   = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_size,
   input logic              req_write,
   input logic [31:0]       req_wdata,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic              rsp_uncache,
   input logic              rsp_regmap,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata
);
   logic [28:0] code;
   logic        io_ok, reg_acc, win_acc;
   logic [31:0] seen_cfg;

   assign code    = req_addr[63:35];
   assign io_ok   = req_valid && code == 29'd2 && req_addr[34:19] == 16'd0;
   assign reg_acc = io_ok && req_addr[18:3] == 16'h0CF8 && req_size == 4'd4;
   assign win_acc = io_ok && req_addr[18:5] == 14'h033F;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_cfg <= '0;
      else if (reg_acc && req_write) seen_cfg <= req_wdata;
   end

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_err, rsp_regmap, rsp_uncache}));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || rsp_err) |-> (rsp_paddr == '0 && !rsp_uncache && !rsp_regmap && rsp_rdata == '0));

   assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && code != 29'd1 && code != 29'd2) |-> rsp_err);

   assert_window_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_acc |-> (rsp_paddr[1:0] == req_addr[4:3] && rsp_uncache));

   assert_cfg_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_acc && !req_write) |-> (rsp_rdata == seen_cfg && rsp_regmap));
endmodule

bind ispace_decoder ispace_checker #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_ispace_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
   .rsp_paddr(rsp_paddr), .rsp_uncache(rsp_uncache), .rsp_regmap(rsp_regmap),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/test_ispace_decoder.sv
`timescale 1ns/1ps
module test_ispace_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [63:0] rsp_paddr;
   logic        rsp_uncache, rsp_regmap, rsp_err;
   logic [31:0] rsp_rdata;

   int unsigned checks = 0;
   int unsigned errors = 0;
   logic [31:0] model_cfg = '0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ispace_decoder i_ispace_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_paddr(rsp_paddr), .rsp_uncache(rsp_uncache), .rsp_regmap(rsp_regmap),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [63:0] mk_addr(logic [28:0] code, logic [31:0] ofs);
      return {code, ofs, 3'b101};
   endfunction

   // expected {err, regmap, uncache, paddr, rdata}
   function automatic logic [98:0] expect_rsp(logic v, logic [63:0] a, logic [3:0] sz, logic [31:0] cfg);
      logic [28:0] c;
      logic [31:0] o;
      c = a[63:35];
      o = a[34:3];
      if (!v) return '0;
      if (c == 29'd1) return {1'b0, 1'b1, 1'b0, 29'd0, o, 3'd0, 32'd0};
      if (c != 29'd2) return {1'b1, 98'd0};
      if (o[31:16] != 0) return {1'b1, 98'd0};
      if (o[15:0] == 16'h0CF8 && sz == 4'd4)
         return {1'b0, 1'b1, 1'b0, 64'h400, cfg};
      if (o[15:0] >= 16'h0CFC && o[15:0] <= 16'h0CFF && cfg[31])
         return {1'b0, 1'b0, 1'b1, 64'hC000_0000_0000_0000 | {32'd0, cfg[30:2], o[1:0]}, 32'd0};
      return {1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0000 | {48'd0, o[15:0]}, 32'd0};
   endfunction

   task automatic check(string req);
      logic [98:0] exp, got;
      exp = expect_rsp(req_valid, req_addr, req_size, model_cfg);
      got = {rsp_err, rsp_regmap, rsp_uncache, rsp_paddr, rsp_rdata};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: addr=%h got=%h exp=%h", req, req_addr, got, exp);
      end
   endtask

   // drive at negedge, check mid-low phase, let posedge update the register
   task automatic apply(logic v, logic [63:0] a, logic [3:0] sz, logic w, logic [31:0] d, string req);
      @(negedge clk);
      req_valid = v; req_addr = a; req_size = sz; req_write = w; req_wdata = d;
      #1;
      check(req);
      @(posedge clk);
      if (v && a[63:35] == 29'd2 && a[34:19] == 0 && a[18:3] == 16'h0CF8 && sz == 4'd4 && w)
         model_cfg = d;
   endtask

   task automatic read_cfg(string req);
      apply(1'b1, mk_addr(29'd2, 32'h0CF8), 4'd4, 1'b0, 32'hDEAD_BEEF, req);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset value and R9 idle outputs
      apply(1'b0, mk_addr(29'd2, 32'h0CF8), 4'd4, 1'b0, 0, "R9 idle");
      read_cfg("R10 reset value");
      // R2 register space
      apply(1'b1, mk_addr(29'd1, 32'h0000_0010), 4'd8, 1'b0, 0, "R2 reg space");
      apply(1'b1, mk_addr(29'd1, 32'hFFFF_FFFF), 4'd8, 1'b1, 0, "R2 reg space max");
      // R1 bad codes
      apply(1'b1, mk_addr(29'd0, 32'h0CF8), 4'd4, 1'b1, 32'hFFFF_FFFF, "R1 code zero");
      apply(1'b1, mk_addr(29'd3, 32'h0CFC), 4'd4, 1'b0, 0, "R1 code three");
      read_cfg("R5 bad code no write");
      // R3 out-of-range port, write ignored
      apply(1'b1, mk_addr(29'd2, 32'h0001_0CF8), 4'd4, 1'b1, 32'h8000_1234, "R3 high port bits");
      read_cfg("R3 no write on error");
      // R7 window disabled
      apply(1'b1, mk_addr(29'd2, 32'h0CFE), 4'd1, 1'b0, 0, "R7 window disabled");
      // R4/R5 write with enable
      apply(1'b1, mk_addr(29'd2, 32'h0CF8), 4'd4, 1'b1, 32'h8012_3457, "R4 cfg write");
      read_cfg("R5 cfg readback");
      apply(1'b1, mk_addr(29'd2, 32'h0CFC), 4'd4, 1'b0, 0, "R6 window low");
      apply(1'b1, mk_addr(29'd2, 32'h0CFF), 4'd1, 1'b1, 0, "R6 window high");
      // R8 size mismatch at 0xCF8
      apply(1'b1, mk_addr(29'd2, 32'h0CF8), 4'd2, 1'b1, 32'h0, "R8 cf8 size 2");
      read_cfg("R5 size 2 no write");
      apply(1'b1, mk_addr(29'd2, 32'h0CFB), 4'd1, 1'b0, 0, "R8 port below window");
      apply(1'b1, mk_addr(29'd2, 32'h0D00), 4'd1, 1'b0, 0, "R8 port above window");
      apply(1'b1, mk_addr(29'd2, 32'hFFFF), 4'd2, 1'b0, 0, "R8 top port");
      // R7 after clearing enable
      apply(1'b1, mk_addr(29'd2, 32'h0CF8), 4'd4, 1'b1, 32'h7FFF_FFFF, "R5 disable write");
      apply(1'b1, mk_addr(29'd2, 32'h0CFD), 4'd1, 1'b0, 0, "R7 window after disable");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r, ofs;
         logic [28:0] code;
         logic [3:0]  sz;
         r = $urandom;
         sz = (r[1:0] == 0) ? 4'd1 : (r[1:0] == 1) ? 4'd2 : 4'd4;
         ofs = $urandom;
         case (r[5:2] % 8)
            0: code = 29'd1;
            1: begin code = 29'd2; ofs = 32'h0CF8; end
            2, 3: begin code = 29'd2; ofs = 32'h0CFC | {30'd0, r[7:6]}; end
            4, 5: begin code = 29'd2; ofs = {16'd0, ofs[15:0]}; end
            6: code = 29'd2;
            default: code = {r[31:11], 8'h00} | 29'd3;
         endcase
         apply(r[8] | r[9], mk_addr(code, ofs), sz, r[10], $urandom,
               "R1 R2 R3 R4 R5 R6 R7 R8 random");
      end
      @(negedge clk);
      req_valid = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule